// File: doc/BRIEF.md
# Temperature Update and Tuning Offset Sequencer

This block finishes each temperature-update cycle of a compensated oscillator. A sensor front end runs conversions back to back from power-up, one every few hundred milliseconds. At the end of each one it raises a single-cycle done strobe that carries a 10-bit two's complement result in quarter-degree steps. On that strobe the block stores the result left-justified in a 16-bit register, ready for a byte-wide bus. The upper byte then holds the sign and the whole degrees. The top two bits of the lower byte hold the half and quarter degree, and the rest of the lower byte is zero.

In the same step the block reads a factory compensation word for the present temperature. This word comes from a table outside the block. The block adds the user's signed tuning byte to it, where one step is about 0.08 ppm. The sum is clamped to the width of the crystal loading register and written there. A new tuning byte therefore takes effect only at the next update cycle. Between strobes both registers keep the last completed result, however the inputs move.

Top module: `temp_tune_seq`

## Requirements
- R1: While reset is held, and after it until the first done strobe, the temperature register and the loading register both read zero.
- R2: On a done strobe, the temperature register takes the 10-bit result in bits 15:6 and zero in bits 5:0. Examples: a raw value of 154h (+85 °C) gives 5500h, 3FEh (-0.5 °C) gives FF80h, and 360h (-40 °C) gives D800h.
- R3: With no done strobe, the temperature register keeps its value whatever the result input does.
- R4: On a done strobe, the loading register takes the unsigned factory word plus the sign-extended tuning byte whenever that sum is between 0 and 2^LOAD_W-1.
- R5: A change of the tuning byte without a done strobe leaves the loading register unchanged. The new byte is applied at the next strobe.
- R6: A sum above 2^LOAD_W-1 loads 2^LOAD_W-1 (4095 at the default width).
- R7: A sum below zero loads zero.
- R8: Both registers change on the clock edge that samples the done strobe high, so they are visible one cycle after the strobe. Before that edge they still show the previous values.
- R9: A change of the factory word without a done strobe leaves the loading register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | Single-cycle strobe at the end of a conversion |
| conv_temp | input | TEMP_W (10) | Conversion result, two's complement, 0.25 °C per LSB |
| factory_load | input | LOAD_W (12) | Factory loading word for the present temperature, unsigned |
| tune_byte | input | TUNE_W (8) | User tuning offset, two's complement |
| temp_reg | output | REG_W (16) | Left-justified temperature for the bus |
| load_reg | output | LOAD_W (12) | Crystal loading register |

## Verification
Both results fall due on the edge that samples the strobe. The bench drives the strobe at a falling edge and lowers it at the next falling edge. At that second falling edge it checks the new values, because exactly one rising edge lies between the two. At the drive point it also checks that the previous values still stand, which pins the update to that single edge. The hold requirements use the same timing: the inputs move over several idle cycles, the outputs are sampled at falling edges, and only then does the next strobe arrive.

// File: rtl/temp_tune_seq.sv
module temp_tune_seq #(
  parameter int TEMP_W = 10,
  parameter int TUNE_W = 8,
  parameter int LOAD_W = 12,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [TEMP_W-1:0] conv_temp,
  input  logic [LOAD_W-1:0] factory_load,
  input  logic [TUNE_W-1:0] tune_byte,
  output logic [REG_W-1:0]  temp_reg,
  output logic [LOAD_W-1:0] load_reg
);
  localparam int PAD_W = REG_W - TEMP_W;
  localparam int SUM_W = LOAD_W + 2;

  logic [SUM_W-1:0]  sum;
  logic [LOAD_W-1:0] sat;

  assign sum = {2'b00, factory_load} + {{(SUM_W-TUNE_W){tune_byte[TUNE_W-1]}}, tune_byte};

  always_comb begin
    if (sum[SUM_W-1])
      sat = '0;
    else if (sum[SUM_W-2])
      sat = '1;
    else
      sat = sum[LOAD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_reg <= '0;
      load_reg <= '0;
    end else if (conv_done) begin
      temp_reg <= {conv_temp, {PAD_W{1'b0}}};
      load_reg <= sat;
    end
  end
endmodule

module temp_tune_seq_chk #(
  parameter int TEMP_W = 10,
  parameter int TUNE_W = 8,
  parameter int LOAD_W = 12,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [TEMP_W-1:0] conv_temp,
  input logic [LOAD_W-1:0] factory_load,
  input logic [TUNE_W-1:0] tune_byte,
  input logic [REG_W-1:0]  temp_reg,
  input logic [LOAD_W-1:0] load_reg
);
  int ref_sum;
  int max_val;
  assign ref_sum = int'(factory_load) + int'($signed(tune_byte));
  assign max_val = (1 << LOAD_W) - 1;

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (temp_reg == '0 && load_reg == '0));

  // R2
  temp_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> temp_reg == {$past(conv_temp), {(REG_W-TEMP_W){1'b0}}});

  // R3
  temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(temp_reg));

  // R5
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(load_reg));

  // R4
  load_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && ref_sum >= 0 && ref_sum <= max_val) |=> int'(load_reg) == $past(ref_sum));

  // R6
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && ref_sum > max_val) |=> load_reg == '1);

  // R7
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && ref_sum < 0) |=> load_reg == '0);
endmodule

bind temp_tune_seq temp_tune_seq_chk #(
  .TEMP_W(TEMP_W), .TUNE_W(TUNE_W), .LOAD_W(LOAD_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_temp(conv_temp),
  .factory_load(factory_load), .tune_byte(tune_byte),
  .temp_reg(temp_reg), .load_reg(load_reg)
);

// File: tb/temp_tune_seq_test.sv
module temp_tune_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_temp = '0;
  logic [11:0] factory_load = '0;
  logic [7:0]  tune_byte = '0;
  logic [15:0] temp_reg;
  logic [11:0] load_reg;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  temp_tune_seq uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_temp(conv_temp),
    .factory_load(factory_load), .tune_byte(tune_byte),
    .temp_reg(temp_reg), .load_reg(load_reg)
  );

  // {temp 10, tune 8, factory 12, expected temp 16, expected load 12}
  localparam int NV = 9;
  localparam logic [57:0] VEC [NV] = '{
    {10'h154, 8'h00, 12'd2048, 16'h5500, 12'd2048},
    {10'h3FE, 8'hFF, 12'd1000, 16'hFF80, 12'd999},
    {10'h360, 8'h7F, 12'd1000, 16'hD800, 12'd1127},
    {10'h000, 8'h7F, 12'd4000, 16'h0000, 12'd4095},
    {10'h12C, 8'h80, 12'd50,   16'h4B00, 12'd0},
    {10'h002, 8'h00, 12'd4095, 16'h0080, 12'd4095},
    {10'h3B0, 8'h80, 12'd128,  16'hEC00, 12'd0},
    {10'h1FF, 8'h01, 12'd0,    16'h7FC0, 12'd1},
    {10'h200, 8'hFF, 12'd4095, 16'h8000, 12'd4094}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [9:0] t, input logic [7:0] tb, input logic [11:0] f);
    @(negedge clk);
    conv_temp = t; tune_byte = tb; factory_load = f; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pt;
    logic [11:0] pl;
    repeat (3) @(negedge clk);
    check("R1 temp in reset", 32'(temp_reg), 0);
    check("R1 load in reset", 32'(load_reg), 0);
    rst_n = 1'b1;
    conv_temp = 10'h155; factory_load = 12'd777; tune_byte = 8'h11;
    repeat (4) @(negedge clk);
    check("R1 temp before first strobe", 32'(temp_reg), 0);
    check("R1 load before first strobe", 32'(load_reg), 0);

    for (int i = 0; i < NV; i++) begin
      pt = temp_reg; pl = load_reg;
      @(negedge clk);
      {conv_temp, tune_byte, factory_load} = VEC[i][57:28];
      conv_done = 1'b1;
      check("R8 temp still old at strobe", 32'(temp_reg), 32'(pt));
      check("R8 load still old at strobe", 32'(load_reg), 32'(pl));
      @(negedge clk);
      conv_done = 1'b0;
      check("R2 temp format", 32'(temp_reg), 32'(VEC[i][27:12]));
      check("R4 R6 R7 load sum", 32'(load_reg), 32'(VEC[i][11:0]));
    end

    strobe(10'h0A0, 8'h05, 12'd2000);
    check("R4 load 2005", 32'(load_reg), 2005);
    check("R2 temp 40C", 32'(temp_reg), 32'h2800);
    @(negedge clk) tune_byte = 8'h40;
    repeat (3) @(negedge clk);
    check("R5 load ignores new tune", 32'(load_reg), 2005);
    factory_load = 12'd100;
    conv_temp = 10'h3FF;
    repeat (3) @(negedge clk);
    check("R9 load ignores new factory", 32'(load_reg), 2005);
    check("R3 temp holds", 32'(temp_reg), 32'h2800);
    strobe(10'h3FF, 8'h40, 12'd100);
    check("R5 new tune applied at strobe", 32'(load_reg), 164);
    check("R2 temp -0.25C", 32'(temp_reg), 32'hFFC0);
    strobe(10'h000, 8'h81, 12'd127);
    check("R7 exact zero edge", 32'(load_reg), 0);
    strobe(10'h000, 8'h01, 12'd4095);
    check("R6 one above max", 32'(load_reg), 4095);

    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 temp after mid reset", 32'(temp_reg), 0);
    check("R1 load after mid reset", 32'(load_reg), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule